// File: doc/BRIEF.md
# Initiator Disconnect Watch Register

This block is a byte-wide control register that sits beside the bus core of a SCSI initiator. It watches for a Bus Free condition that the initiator did not expect. When the sequencer reports a successful selection or a reselection, hardware arms an "unexpected disconnect" bit. If the bus then enters Bus Free while the core is acting as initiator, the block raises a one-cycle error pulse and disarms the bit, so the error is reported only once. Software disarms the bit by writing 0 before a disconnect it expects, such as ahead of an abort or bus-reset message, or after command completion.

The same register holds a chained-transfer bit, a wide-send flag and two controls for an external 16-bit parity accumulator: a word-mode enable and a high-byte select. When word mode is off, the accumulator behaves as a single legacy byte and the high-byte select is forced low. The three lowest bits are read-only status that is supplied from outside the block.

Top module: `disc_watch_reg`

## Requirements
- R1: After reset, bits 7 to 3 of the register read 0, `disc_err` is 0 and all control outputs are 0.
- R2: Readback layout of `rd_data`: bit 7 is the armed disconnect bit, bit 6 is chained mode, bit 5 is parity word mode, bit 4 is parity high-byte enable, bit 3 is the wide-send flag, and bits 2:0 show `stat_in`.
- R3: A pulse on `sel_done` or `resel` sets bit 7 at the next clock edge, whatever the role.
- R4: When `bus_free` goes from 0 to 1 while bit 7 is set and `role_init` is 1, `disc_err` is 1 for exactly the one cycle after that edge. A level held high gives no further pulse.
- R5: The edge that raises `disc_err` also clears bit 7, so a later Bus Free reports nothing unless bit 7 is set again.
- R6: While `role_init` is 0, Bus Free never raises `disc_err` and leaves bit 7 unchanged.
- R7: A host write with bit 7 equal to 0 clears bit 7, and a later Bus Free then gives no error.
- R8: When a hardware set event and a host write of 0 to bit 7, or an error clear, fall in the same cycle, bit 7 ends up set.
- R9: `par_word_mode` follows bit 5. `par_hi_sel` equals bit 4 when bit 5 is 1 and is 0 when bit 5 is 0.
- R10: Host writes do not change bits 2:0. These bits always show `stat_in`.
- R11: Bits 6 to 3 take the written value on a host write and otherwise hold it. `chain_mode` follows bit 6.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Host write strobe |
| wr_data | input | 8 | Host write data |
| rd_data | output | 8 | Register readback |
| sel_done | input | 1 | Sequencer pulse: selection succeeded |
| resel | input | 1 | Sequencer pulse: core was reselected |
| role_init | input | 1 | 1 while the core acts as initiator |
| bus_free | input | 1 | Bus Free level from the phase logic |
| stat_in | input | 3 | Read-only status shown in bits 2:0 |
| disc_err | output | 1 | Unexpected-disconnect pulse |
| chain_mode | output | 1 | Chained-transfer mode |
| par_word_mode | output | 1 | Parity accumulator word mode |
| par_hi_sel | output | 1 | Parity accumulator high-byte select |

## Verification
The assertions assume that `bus_free` and the event pulses are synchronous to `clk` and stable across each edge. They also assume that `sel_done` and `resel` last a single cycle per event. The bench meets these assumptions by changing every input only on the falling edge and by driving each event for exactly one cycle. The bench also holds `bus_free` low for at least one cycle before each new Bus Free, so that every intended rising edge is seen.

// File: rtl/dwr_pkg.sv
package dwr_pkg;
    localparam int REG_W   = 8;
    localparam int STAT_W  = 3;
    localparam int B_ARM   = 7;
    localparam int B_CHAIN = 6;
    localparam int B_WMODE = 5;
    localparam int B_HISEL = 4;
    localparam int B_WIDE  = 3;
    localparam int CTRL_W  = B_ARM - STAT_W;

    typedef struct packed {
        logic armed;
        logic bf_prev;
        logic err;
    } watch_st_t;

    typedef struct packed {
        logic chain;
        logic wmode;
        logic hisel;
        logic wide;
    } ctrl_st_t;
endpackage

// File: rtl/dwr_watch.sv
module dwr_watch (
    input  logic clk,
    input  logic rst_n,
    input  logic wr_en,
    input  logic wr_arm,
    input  logic hw_set,
    input  logic role_init,
    input  logic bus_free,
    output logic armed,
    output logic err
);
    import dwr_pkg::*;

    watch_st_t st_d, st_q;
    logic      bf_rise;

    always_comb begin
        st_d         = st_q;
        bf_rise      = bus_free && !st_q.bf_prev;
        st_d.bf_prev = bus_free;
        st_d.err     = bf_rise && st_q.armed && role_init;
        if (wr_en) begin
            st_d.armed = wr_arm;
        end
        if (st_d.err) begin
            st_d.armed = 1'b0;
        end
        if (hw_set) begin
            st_d.armed = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign armed = st_q.armed;
    assign err   = st_q.err;

    // R3
    hw_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hw_set |=> armed);
    // R4
    single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err |=> !err);
    // R6
    target_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !role_init |=> !err);
    // R5
    disarm_after_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (err && !$past(hw_set)) |-> !armed);
endmodule

// File: rtl/dwr_ctrl.sv
module dwr_ctrl (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wr_en,
    input  logic [dwr_pkg::CTRL_W-1:0] wr_ctrl,
    output logic [dwr_pkg::CTRL_W-1:0] ctrl_bits,
    output logic                       chain_mode,
    output logic                       par_word_mode,
    output logic                       par_hi_sel
);
    import dwr_pkg::*;

    ctrl_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            st_d = ctrl_st_t'(wr_ctrl);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign ctrl_bits     = st_q;
    assign chain_mode    = st_q.chain;
    assign par_word_mode = st_q.wmode;
    assign par_hi_sel    = st_q.wmode & st_q.hisel;

    // R11
    ctrl_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(ctrl_bits));
    // R9
    hi_needs_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
        par_hi_sel |-> par_word_mode);
endmodule

// File: rtl/disc_watch_reg.sv
module disc_watch_reg (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic [7:0] wr_data,
    output logic [7:0] rd_data,
    input  logic       sel_done,
    input  logic       resel,
    input  logic       role_init,
    input  logic       bus_free,
    input  logic [2:0] stat_in,
    output logic       disc_err,
    output logic       chain_mode,
    output logic       par_word_mode,
    output logic       par_hi_sel
);
    import dwr_pkg::*;

    logic              armed;
    logic [CTRL_W-1:0] ctrl_bits;

    dwr_watch u_watch (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_arm    (wr_data[B_ARM]),
        .hw_set    (sel_done | resel),
        .role_init (role_init),
        .bus_free  (bus_free),
        .armed     (armed),
        .err       (disc_err)
    );

    dwr_ctrl u_ctrl (
        .clk           (clk),
        .rst_n         (rst_n),
        .wr_en         (wr_en),
        .wr_ctrl       (wr_data[B_ARM-1:STAT_W]),
        .ctrl_bits     (ctrl_bits),
        .chain_mode    (chain_mode),
        .par_word_mode (par_word_mode),
        .par_hi_sel    (par_hi_sel)
    );

    assign rd_data = {armed, ctrl_bits, stat_in};

    // R10
    status_view_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data[STAT_W-1:0] == stat_in);
endmodule

// File: tb/disc_watch_reg_tb.sv
`timescale 1ns/1ps
module disc_watch_reg_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic [7:0] rd_data;
    logic       sel_done = 1'b0, resel = 1'b0, role_init = 1'b1, bus_free = 1'b0;
    logic [2:0] stat_in = '0;
    logic       disc_err, chain_mode, par_word_mode, par_hi_sel;

    int n_chk = 0;
    int n_bad = 0;

    always #2 clk = ~clk;

    disc_watch_reg u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .rd_data(rd_data), .sel_done(sel_done), .resel(resel),
        .role_init(role_init), .bus_free(bus_free), .stat_in(stat_in),
        .disc_err(disc_err), .chain_mode(chain_mode),
        .par_word_mode(par_word_mode), .par_hi_sel(par_hi_sel)
    );

    // fields: we, wd[8], sel, rsl, ini, bf, aux[3], exp_rd[8], exp_err, exp_hi, exp_chain, req[4]
    localparam int VW = 31;
    localparam int NV = 16;
    localparam logic [VW-1:0] VEC [NV] = '{
        {1'b0, 8'h00, 1'b0, 1'b0, 1'b1, 1'b0, 3'b000, 8'h00, 1'b0, 1'b0, 1'b0, 4'd1},  // R1 idle
        {1'b0, 8'h00, 1'b1, 1'b0, 1'b1, 1'b0, 3'b000, 8'h80, 1'b0, 1'b0, 1'b0, 4'd3},  // R3 selection
        {1'b0, 8'h00, 1'b0, 1'b0, 1'b1, 1'b1, 3'b000, 8'h00, 1'b1, 1'b0, 1'b0, 4'd4},  // R4 error
        {1'b0, 8'h00, 1'b0, 1'b0, 1'b1, 1'b1, 3'b000, 8'h00, 1'b0, 1'b0, 1'b0, 4'd5},  // R5 held level
        {1'b0, 8'h00, 1'b0, 1'b1, 1'b1, 1'b0, 3'b000, 8'h80, 1'b0, 1'b0, 1'b0, 4'd3},  // R3 reselect
        {1'b0, 8'h00, 1'b0, 1'b0, 1'b1, 1'b1, 3'b000, 8'h00, 1'b1, 1'b0, 1'b0, 4'd4},  // R4 again
        {1'b0, 8'h00, 1'b1, 1'b0, 1'b0, 1'b0, 3'b000, 8'h80, 1'b0, 1'b0, 1'b0, 4'd6},  // R6 set as target
        {1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b1, 3'b000, 8'h80, 1'b0, 1'b0, 1'b0, 4'd6},  // R6 no error
        {1'b1, 8'h00, 1'b0, 1'b0, 1'b1, 1'b0, 3'b000, 8'h00, 1'b0, 1'b0, 1'b0, 4'd7},  // R7 sw clear
        {1'b0, 8'h00, 1'b0, 1'b0, 1'b1, 1'b1, 3'b000, 8'h00, 1'b0, 1'b0, 1'b0, 4'd7},  // R7 no error
        {1'b1, 8'h00, 1'b1, 1'b0, 1'b1, 1'b0, 3'b000, 8'h80, 1'b0, 1'b0, 1'b0, 4'd8},  // R8 hw wins
        {1'b1, 8'h7F, 1'b0, 1'b0, 1'b1, 1'b0, 3'b101, 8'h7D, 1'b0, 1'b1, 1'b1, 4'd10}, // R10 R11
        {1'b1, 8'h10, 1'b0, 1'b0, 1'b1, 1'b0, 3'b000, 8'h10, 1'b0, 1'b0, 1'b0, 4'd9},  // R9 hi w/o mode
        {1'b1, 8'h20, 1'b0, 1'b0, 1'b1, 1'b0, 3'b010, 8'h22, 1'b0, 1'b0, 1'b0, 4'd9},  // R9 mode, low
        {1'b1, 8'hC8, 1'b0, 1'b0, 1'b1, 1'b0, 3'b000, 8'hC8, 1'b0, 1'b0, 1'b1, 4'd11}, // R11 sw arm
        {1'b0, 8'h00, 1'b0, 1'b0, 1'b1, 1'b1, 3'b000, 8'h48, 1'b1, 1'b0, 1'b1, 4'd2}   // R2 R4
    };

    task automatic check(input string req, input string what, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic step;
        @(posedge clk);
        #1;
    endtask

    task automatic drive_idle;
        @(negedge clk);
        wr_en = 0; wr_data = '0; sel_done = 0; resel = 0; bus_free = 0; role_init = 1; stat_in = '0;
    endtask

    initial begin
        #(4 * 100000);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1", "rd_data in reset", rd_data, 8'h00);
        check("R1", "disc_err in reset", {7'd0, disc_err}, 8'h00);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            logic [VW-1:0] v;
            string rq;
            v = VEC[i];
            @(negedge clk);
            {wr_en, wr_data, sel_done, resel, role_init, bus_free, stat_in} = v[VW-1:15];
            #1;
            step();
            rq = $sformatf("R%0d", v[3:0]);
            check(rq, $sformatf("vec %0d rd_data", i), rd_data, v[14:7]);
            check(rq, $sformatf("vec %0d disc_err", i), {7'd0, disc_err}, {7'd0, v[6]});
            check(rq, $sformatf("vec %0d par_hi_sel", i), {7'd0, par_hi_sel}, {7'd0, v[5]});
            check(rq, $sformatf("vec %0d chain_mode", i), {7'd0, chain_mode}, {7'd0, v[4]});
        end

        // R9: word mode with high byte selected
        drive_idle();
        wr_en = 1; wr_data = 8'h30;
        step();
        check("R9", "par_word_mode", {7'd0, par_word_mode}, 8'h01);
        check("R9", "par_hi_sel", {7'd0, par_hi_sel}, 8'h01);

        // R8: set event coincides with error clear
        drive_idle();
        sel_done = 1;
        step();
        drive_idle();
        bus_free = 1; resel = 1;
        step();
        check("R8", "disc_err on coincident set", {7'd0, disc_err}, 8'h01);
        check("R8", "armed bit after coincident set", {7'd0, rd_data[7]}, 8'h01);

        // R1: reset in mid-run clears everything
        drive_idle();
        wr_en = 1; wr_data = 8'hF8;
        step();
        drive_idle();
        rst_n = 0;
        #1;
        check("R1", "rd_data after reset", rd_data, 8'h00);
        check("R1", "par_word_mode after reset", {7'd0, par_word_mode}, 8'h00);
        rst_n = 1;

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule